// File: doc/BRIEF.md
# Measurement Channel Sequencer

This block schedules conversions for a multi-channel measurement converter. It picks the next channel, drives the channel select and a one-cycle start pulse to the converter, and waits a conversion time. That time depends on the channel type and on a fast/slow timing input. When the time is up it takes the 10-bit converter result. Each channel has its own value register, and the result goes there either at once or as the floor mean of sixteen consecutive conversions of that channel.

Two pins are shared. A configuration input decides whether they form one remote temperature diode channel or two separate analog inputs. A second input marks a third pin as the DAC load strobe, and its analog channel then drops out of the list. In round-robin mode the sequencer runs through the channel list without stopping and pulses a flag at the end of each full pass. In single mode it converts one selected channel over and over. A standby input halts the sequencer once the conversion in flight completes. After standby is released it starts again from the first channel.

Top module: `meas_sequencer`

## Requirements
- R1: During and after reset all seven value registers read 0, and `conv_start`, `res_we` and `cycle_done` are low. While `standby` is high after reset no conversion starts.
- R2: With `pair_is_diode`=1, `pin3_is_load`=0 and round-robin mode, channels are written in the repeating order 0,1,2,5,6. Channel codes: 0 supply, 1 internal temperature, 2 remote temperature, 3 AIN1, 4 AIN2, 5 AIN3, 6 AIN4.
- R3: With `pair_is_diode`=0 and `pin3_is_load`=0, the repeating order is 0,1,3,4,5,6.
- R4: With `pin3_is_load`=1, channel 5 is skipped. For `pair_is_diode`=0 the order is 0,1,3,4,6.
- R5: With `single_mode`=1, only channel `single_sel` is converted, repeatedly, and `cycle_done` never pulses.
- R6: `res_we` goes high exactly L cycles after the `conv_start` of the conversion that completes the result. L is LAT_SLOW_REM (16) for channel 2 and LAT_SLOW_STD (8) for the others when `fast_mode`=0. With `fast_mode`=1 it is LAT_FAST_REM (5) for channel 2 and LAT_FAST_STD (2) for the others.
- R7: With `avg_en`=0, every write stores the value `conv_data` held for the conversion just finished.
- R8: With `avg_en`=1, a channel's register is written only after its 16th conversion. The stored value is the 14-bit sum of the 16 results shifted right by 4.
- R9: `cycle_done` pulses for one cycle, together with the `res_we` of channel 6, at the end of each round-robin pass.
- R10: A `standby` that rises during a conversion allows exactly that one conversion to finish and be written, and then no further start follows. After release, the first start selects channel 0.
- R11: Value register i sits at `chan_results[10*i+9:10*i]`. A write changes only the slot of the channel written, and the slots do not change in cycles without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pair_is_diode | input | 1 | 1: shared pins form the remote diode channel; 0: two analog inputs |
| pin3_is_load | input | 1 | 1: third analog pin used as DAC load, its channel skipped |
| fast_mode | input | 1 | Selects the short conversion times |
| avg_en | input | 1 | Enables 16-sample averaging |
| single_mode | input | 1 | Converts only `single_sel` |
| single_sel | input | 3 | Channel code used in single mode |
| standby | input | 1 | Halts after the current conversion |
| conv_data | input | 10 | Converter result, valid by the last cycle of a conversion |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_sel | output | 3 | Channel select to the converter mux |
| res_we | output | 1 | Pulse: a value register was written |
| res_ch | output | 3 | Channel of the last write |
| cycle_done | output | 1 | Pulse at the end of a round-robin pass |
| chan_results | output | 70 | Seven 10-bit value registers, channel i at bits 10i+9..10i |

## Verification
The bench drives each shared-pin setting and the skip of the third pin and compares the written channel order over two whole passes. A design with a wrong successor would drop or repeat a channel, or would not return to channel 0. A converter model in the bench changes its result on every conversion, so a sequencer that samples one cycle too early or too late stores another sample's value, and the bench also checks the start-to-write distance against the expected latency. In averaging, a wrong count or a sum that is not shifted shows up as the wrong number of starts between writes or as a value 16 times too large. In the standby test, a halt that does not wait for the conversion in flight loses that write. A halt that does not stop the sequencer shows as further starts, and a restart that resumes mid-list selects a channel other than 0.

// File: rtl/meas_seq_pkg.sv
package meas_seq_pkg;

  localparam int CH_W = 3;
  localparam int NCH  = 7;

  typedef enum logic [CH_W-1:0] {
    CH_VDD  = 3'd0,
    CH_TINT = 3'd1,
    CH_TREM = 3'd2,
    CH_AIN1 = 3'd3,
    CH_AIN2 = 3'd4,
    CH_AIN3 = 3'd5,
    CH_AIN4 = 3'd6
  } chan_e;

  typedef enum logic {S_IDLE = 1'b0, S_RUN = 1'b1} seq_st_e;

  // successor in the round-robin list
  function automatic chan_e rr_next(chan_e cur, logic diode, logic skip3);
    case (cur)
      CH_VDD:           rr_next = CH_TINT;
      CH_TINT:          rr_next = diode ? CH_TREM : CH_AIN1;
      CH_AIN1:          rr_next = CH_AIN2;
      CH_TREM, CH_AIN2: rr_next = skip3 ? CH_AIN4 : CH_AIN3;
      CH_AIN3:          rr_next = CH_AIN4;
      default:          rr_next = CH_VDD;
    endcase
  endfunction

  // out-of-range codes fall back to the supply channel
  function automatic chan_e legal_chan(logic [CH_W-1:0] code);
    legal_chan = (code > 3'd6) ? CH_VDD : chan_e'(code);
  endfunction

endpackage

// File: rtl/seq_step.sv
module seq_step
  import meas_seq_pkg::*;
(
  input  chan_e             cur,
  input  logic              pair_is_diode,
  input  logic              pin3_is_load,
  input  logic              single_mode,
  input  logic [CH_W-1:0]   single_sel,
  output chan_e             first_ch,
  output chan_e             nxt_ch,
  output logic              wrap
);
  always_comb begin
    first_ch = single_mode ? legal_chan(single_sel) : CH_VDD;
    nxt_ch   = single_mode ? legal_chan(single_sel)
                           : rr_next(cur, pair_is_diode, pin3_is_load);
    wrap     = !single_mode && (cur == CH_AIN4);
  end
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int LAT_SLOW_STD = 8,
  parameter int LAT_SLOW_REM = 16,
  parameter int LAT_FAST_STD = 2,
  parameter int LAT_FAST_REM = 5,
  localparam int LAT_MAX = (LAT_SLOW_REM > LAT_SLOW_STD) ? LAT_SLOW_REM : LAT_SLOW_STD,
  localparam int CNT_W   = $clog2(LAT_MAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic remote,
  input  logic fast,
  output logic busy,
  output logic expire
);
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] lat_m1(logic rem, logic f);
    int l;
    if (f) l = rem ? LAT_FAST_REM : LAT_FAST_STD;
    else   l = rem ? LAT_SLOW_REM : LAT_SLOW_STD;
    lat_m1 = CNT_W'(l - 1);
  endfunction

  assign expire = busy && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      cnt_q <= lat_m1(remote, fast);
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // R6: a new conversion is never launched over one still running
  assert_load_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!busy || expire));
endmodule

// File: rtl/avg_accum.sv
module avg_accum #(
  parameter int RES_W   = 10,
  parameter int AVG_LOG = 4,
  localparam int ACC_W  = RES_W + AVG_LOG,
  localparam int ACC_MAX = ((1 << AVG_LOG) - 1) * ((1 << RES_W) - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic             en,
  input  logic [RES_W-1:0] sample,
  output logic             wr,
  output logic [RES_W-1:0] val
);
  logic [ACC_W-1:0]   acc_q;
  logic [AVG_LOG-1:0] n_q;
  logic [ACC_W-1:0]   sum;
  logic               last;

  function automatic logic [RES_W-1:0] mean_of(logic [ACC_W-1:0] s);
    mean_of = s[ACC_W-1:AVG_LOG];
  endfunction

  assign last = (n_q == '1);
  assign sum  = acc_q + ACC_W'(sample);
  assign wr   = take && (!en || last);
  assign val  = en ? mean_of(sum) : sample;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc_q <= '0;
      n_q   <= '0;
    end else if (take && en) begin
      if (last) begin
        acc_q <= '0;
        n_q   <= '0;
      end else begin
        acc_q <= sum;
        n_q   <= n_q + 1'b1;
      end
    end
  end

  // R8: the partial sum never exceeds fifteen full-scale samples
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= ACC_W'(ACC_MAX));
  // R8: an empty sample count always comes with an empty sum
  assert_empty_sum_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (n_q == '0) |-> (acc_q == '0));
endmodule

// File: rtl/result_bank.sv
module result_bank
  import meas_seq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  chan_e                ch,
  input  logic [RES_W-1:0]     din,
  output logic [NCH*RES_W-1:0] flat
);
  for (genvar i = 0; i < NCH; i++) begin : g_slot
    logic [RES_W-1:0] r_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                        r_q <= '0;
      else if (we && (ch == chan_e'(i))) r_q <= din;
    end
    assign flat[i*RES_W +: RES_W] = r_q;
  end

  // R11: value registers only move on a write
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(flat));
endmodule

// File: rtl/meas_sequencer.sv
module meas_sequencer
  import meas_seq_pkg::*;
#(
  parameter int RES_W        = 10,
  parameter int AVG_LOG      = 4,
  parameter int LAT_SLOW_STD = 8,
  parameter int LAT_SLOW_REM = 16,
  parameter int LAT_FAST_STD = 2,
  parameter int LAT_FAST_REM = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pair_is_diode,
  input  logic                 pin3_is_load,
  input  logic                 fast_mode,
  input  logic                 avg_en,
  input  logic                 single_mode,
  input  logic [2:0]           single_sel,
  input  logic                 standby,
  input  logic [RES_W-1:0]     conv_data,
  output logic                 conv_start,
  output logic [2:0]           conv_sel,
  output logic                 res_we,
  output logic [2:0]           res_ch,
  output logic                 cycle_done,
  output logic [NCH*RES_W-1:0] chan_results
);
  seq_st_e          st_q;
  chan_e            cur_q, first_ch, nxt_ch, launch_ch;
  logic             wrap, launch_go;
  logic             t_busy, t_expire;
  logic             acc_wr;
  logic [RES_W-1:0] acc_val;

  seq_step u_step (
    .cur(cur_q), .pair_is_diode(pair_is_diode), .pin3_is_load(pin3_is_load),
    .single_mode(single_mode), .single_sel(single_sel),
    .first_ch(first_ch), .nxt_ch(nxt_ch), .wrap(wrap)
  );

  // launch decision: leave idle, or chain the next conversion
  always_comb begin
    if (st_q == S_IDLE) begin
      launch_go = !standby;
      launch_ch = first_ch;
    end else begin
      launch_go = t_expire && !standby;
      launch_ch = acc_wr ? nxt_ch : cur_q;
    end
  end

  conv_timer #(
    .LAT_SLOW_STD(LAT_SLOW_STD), .LAT_SLOW_REM(LAT_SLOW_REM),
    .LAT_FAST_STD(LAT_FAST_STD), .LAT_FAST_REM(LAT_FAST_REM)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .load(launch_go),
    .remote(launch_ch == CH_TREM), .fast(fast_mode),
    .busy(t_busy), .expire(t_expire)
  );

  avg_accum #(.RES_W(RES_W), .AVG_LOG(AVG_LOG)) u_avg (
    .clk(clk), .rst_n(rst_n), .clr(st_q == S_IDLE), .take(t_expire),
    .en(avg_en), .sample(conv_data), .wr(acc_wr), .val(acc_val)
  );

  result_bank #(.RES_W(RES_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(acc_wr), .ch(cur_q), .din(acc_val),
    .flat(chan_results)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      cur_q      <= CH_VDD;
      conv_start <= 1'b0;
      res_we     <= 1'b0;
      res_ch     <= '0;
      cycle_done <= 1'b0;
    end else begin
      conv_start <= launch_go;
      res_we     <= acc_wr;
      cycle_done <= acc_wr && wrap;
      if (acc_wr)    res_ch <= cur_q;
      if (launch_go) cur_q  <= launch_ch;
      if (st_q == S_IDLE && !standby)               st_q <= S_RUN;
      else if (st_q == S_RUN && t_expire && standby) st_q <= S_IDLE;
    end
  end

  assign conv_sel = cur_q;

  // R9: the pass flag only accompanies the write of the last channel
  assert_pass_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |-> (res_we && res_ch == 3'd6));
  // R10: once halted, no conversion is left running
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE) |-> !t_busy);
  // R5: no pass flag in single mode
  assert_single_nowrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (single_mode && $past(single_mode)) |-> !cycle_done);
endmodule

// File: tb/sim_meas_sequencer.sv
module sim_meas_sequencer;
  localparam int LSS = 8, LSR = 16, LFS = 2, LFR = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pair_is_diode = 1'b1, pin3_is_load = 1'b0, fast_mode = 1'b0;
  logic avg_en = 1'b0, single_mode = 1'b0, standby = 1'b0;
  logic [2:0] single_sel = 3'd0;
  logic [9:0] conv_data = '0;
  logic conv_start, res_we, cycle_done;
  logic [2:0] conv_sel, res_ch;
  logic [69:0] chan_results;

  always #10 clk = ~clk;

  meas_sequencer #(.LAT_SLOW_STD(LSS), .LAT_SLOW_REM(LSR),
                   .LAT_FAST_STD(LFS), .LAT_FAST_REM(LFR)) u0 (
    .clk(clk), .rst_n(rst_n), .pair_is_diode(pair_is_diode),
    .pin3_is_load(pin3_is_load), .fast_mode(fast_mode), .avg_en(avg_en),
    .single_mode(single_mode), .single_sel(single_sel), .standby(standby),
    .conv_data(conv_data), .conv_start(conv_start), .conv_sel(conv_sel),
    .res_we(res_we), .res_ch(res_ch), .cycle_done(cycle_done),
    .chan_results(chan_results));

  int n_chk = 0, n_err = 0;
  int cyc = 0, nwr = 0, ncd = 0, nstart = 0;
  int idx [7], last_st [7], nst [7];
  int wr_seq [64];
  logic [9:0] shadow [7];

  task automatic chk(bit ok, string req, int got, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s got=%0d exp=%0d at cycle %0d", req, got, exp, cyc);
    end
  endtask

  function automatic int pat(int ch, int i);
    return (ch * 131 + i * 37 + (i % 3) * 5) % 1024;
  endfunction

  function automatic int lat(int ch, bit f);
    if (ch == 2) return f ? LFR : LSR;
    return f ? LFS : LSS;
  endfunction

  // converter model and write monitor, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (res_we) begin
        int ch, expv, s;
        ch = res_ch;
        if (nwr < 64) wr_seq[nwr] = ch;
        nwr++;
        if (avg_en) begin
          s = 0;
          for (int k = idx[ch] - 16; k < idx[ch]; k++) s += pat(ch, k);
          expv = s / 16;
          chk(nst[ch] == 16, "R8 starts per write", nst[ch], 16);
          chk(chan_results[ch*10 +: 10] == expv, "R8 mean value", chan_results[ch*10 +: 10], expv);
        end else begin
          expv = pat(ch, idx[ch] - 1);
          chk(chan_results[ch*10 +: 10] == expv, "R7 stored sample", chan_results[ch*10 +: 10], expv);
        end
        chk(cyc - last_st[ch] == lat(ch, fast_mode), "R6 latency", cyc - last_st[ch], lat(ch, fast_mode));
        shadow[ch] = expv[9:0];
        for (int j = 0; j < 7; j++)
          chk(chan_results[j*10 +: 10] == shadow[j], "R11 slot contents", chan_results[j*10 +: 10], shadow[j]);
        nst[ch] = 0;
        if (ch == 6 && !single_mode)
          chk(cycle_done == 1'b1, "R9 pass flag with channel 6", cycle_done, 1);
      end
      if (cycle_done) begin
        ncd++;
        chk(res_we && res_ch == 3'd6, "R9 pass flag placement", res_ch, 6);
      end
      if (conv_start) begin
        nstart++;
        conv_data <= pat(conv_sel, idx[conv_sel]) [9:0];
        last_st[conv_sel] = cyc;
        idx[conv_sel]++;
        nst[conv_sel]++;
      end
    end
  end

  task automatic do_reset(bit diode, bit skip3, bit fast, bit avg, bit single, int sel);
    @(negedge clk);
    rst_n = 1'b0;
    pair_is_diode = diode; pin3_is_load = skip3; fast_mode = fast;
    avg_en = avg; single_mode = single; single_sel = sel[2:0]; standby = 1'b0;
    nwr = 0; ncd = 0; nstart = 0;
    for (int j = 0; j < 7; j++) begin idx[j] = 0; last_st[j] = 0; nst[j] = 0; shadow[j] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_writes(int n);
    int t;
    t = 0;
    while (nwr < n && t < 40000) begin @(negedge clk); t++; end
    chk(nwr >= n, "wait for writes", nwr, n);
  endtask

  task automatic check_order(string req, int n, int e0, int e1, int e2, int e3, int e4, int e5);
    int ex [6];
    ex = '{e0, e1, e2, e3, e4, e5};
    wait_writes(2 * n);
    for (int k = 0; k < 2 * n; k++)
      chk(wr_seq[k] == ex[k % n], req, wr_seq[k], ex[k % n]);
    chk(ncd >= 1, "R9 pass flag seen", ncd, 1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0; standby = 1'b1;
    repeat (3) @(negedge clk);
    chk(chan_results == '0, "R1 registers cleared", 0, 0);
    chk(!conv_start && !res_we && !cycle_done, "R1 outputs low", conv_start, 0);
    nstart = 0;
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(nstart == 0, "R1 no start in standby", nstart, 0);
    chk(chan_results == '0, "R1 registers still clear", 0, 0);
  endtask

  task automatic t_diode;
    do_reset(1, 0, 0, 0, 0, 0);
    check_order("R2 diode order", 5, 0, 1, 2, 5, 6, 0);
  endtask

  task automatic t_analog;
    do_reset(0, 0, 1, 0, 0, 0);
    check_order("R3 analog order", 6, 0, 1, 3, 4, 5, 6);
  endtask

  task automatic t_skip;
    do_reset(0, 1, 0, 0, 0, 0);
    check_order("R4 skip third pin", 5, 0, 1, 3, 4, 6, 0);
    do_reset(1, 1, 1, 0, 0, 0);
    check_order("R4 skip with diode", 4, 0, 1, 2, 6, 0, 0);
  endtask

  task automatic t_single;
    do_reset(1, 0, 0, 0, 1, 2);
    wait_writes(4);
    for (int k = 0; k < 4; k++) chk(wr_seq[k] == 2, "R5 single channel", wr_seq[k], 2);
    chk(ncd == 0, "R5 no pass flag", ncd, 0);
  endtask

  task automatic t_avg;
    do_reset(1, 0, 1, 1, 0, 0);
    check_order("R8 averaged order", 5, 0, 1, 2, 5, 6, 0);
    do_reset(0, 0, 0, 1, 1, 6);
    wait_writes(2);
    chk(nstart >= 32, "R8 sixteen per result", nstart, 32);
  endtask

  task automatic t_standby;
    int w0, s0, t;
    do_reset(1, 0, 0, 0, 0, 0);
    wait_writes(2);
    while (!conv_start) @(negedge clk);
    @(negedge clk);
    standby = 1'b1;
    w0 = nwr; s0 = nstart;
    repeat (60) @(negedge clk);
    chk(nwr == w0 + 1, "R10 in-flight write completes", nwr - w0, 1);
    chk(nstart == s0, "R10 no start after halt", nstart - s0, 0);
    standby = 1'b0;
    t = 0;
    while (!conv_start && t < 10) begin @(negedge clk); t++; end
    chk(conv_start && conv_sel == 3'd0, "R10 restart at channel 0", conv_sel, 0);
  endtask

  initial begin
    t_reset;
    t_diode;
    t_analog;
    t_skip;
    t_single;
    t_avg;
    t_standby;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired got=%0d exp=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule